// File: doc/BRIEF.md
# In-Order Instruction Execute Sequencer

This block sits between instruction fetch and the datapath of a small in-order processor. It accepts one decoded instruction at a time. For each instruction class it drives a fixed series of handshake groups toward the register file ports, the ALU, the memory unit and the program-counter unit. Inside a group, all requests are raised together. The next group starts only after every member of the current group has been acknowledged. One channel is the release handshake that tells fetch it may move on, and its place in the series depends on the class.

Every handshake channel has one bit in `hs_req` and the same bit in `hs_ack`. A request stays high until its partner returns a one-cycle acknowledge, and it drops in the following cycle. For a conditional branch, the flag word on `alu_flags` is sampled when the flag request is acknowledged. That sample decides whether the relative PC update group is issued.

The controller has three named states. IDLE accepts an instruction (transition IDLE→ISSUE on `instr_valid`). ISSUE drives the current group. It moves ISSUE→ADVANCE when the group completes and more groups remain, or ISSUE→IDLE after the last group. ADVANCE holds all requests low for one cycle and steps to the next group (ADVANCE→ISSUE). A group with no members completes in its first ISSUE cycle.

Top module: `exec_sequencer`

## Requirements
- R1: After reset, `instr_ready` is 1 and `hs_req` is all zero.
- R2: Channel bits: 0 fetch release, 1 offset wait, 2 X read, 3 Y read, 4 ALU command, 5 ALU-bus write reservation, 6 result-path request, 7 memory-bus write reservation, 8 memory load, 9 memory store, 10 offset onto X, 11 PC onto X, 12 PC from Y, 13 flag request, 14 relative PC update. A raised request stays high until its acknowledge is seen, then is low in the next cycle.
- R3: Opcodes 0 to 7 (ALU class) issue {release}, then {X read, Y read, ALU command, ALU-bus reservation, result path}. While the ALU command is requested, `alu_op` equals the opcode.
- R4: Opcode 8 (load) issues {release}, then {memory-bus reservation, Y read, memory load}.
- R5: Opcode 9 (store) issues {release}, then {X read, Y read, memory store}.
- R6: Opcode 10 (add-immediate) issues {offset wait}, then {release}, then {offset onto X, Y read, ALU command, ALU-bus reservation}, with `alu_op` = 0 (add).
- R7: Opcode 11 (store-PC) issues {PC onto X, Y read, ALU command, ALU-bus reservation} with `alu_op` = 0, then {release}.
- R8: Opcode 12 (jump) issues {PC from Y, Y read}, then {release}.
- R9: Opcode 13 (branch) issues {offset wait}, then {flag request}, then {relative PC update} only if the condition holds, then {release}. Flag bits are 0 zero, 1 negative, 2 carry. Condition `instr_cc` codes: 0 always, 1 zero set, 2 zero clear, 3 negative set, 4 carry set, 5 to 7 never.
- R10: Opcodes 14 and 15 issue only {release}.
- R11: Requests of a group rise in the same cycle. No request rises while another is pending, and at least one all-low cycle separates consecutive groups.
- R12: `instr_ready` is low from the cycle after acceptance until the last group completes, and it is low whenever any request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decoded instruction offered |
| instr_ready | output | 1 | Sequencer idle, instruction taken when valid |
| instr_op | input | 4 | Instruction opcode |
| instr_cc | input | 3 | Branch condition code |
| alu_flags | input | 4 | Flag word, sampled on flag acknowledge |
| hs_req | output | 15 | Handshake requests, one bit per channel |
| hs_ack | input | 15 | Handshake acknowledges, one-cycle pulses |
| alu_op | output | 4 | ALU operation, valid while the ALU command is requested |

## Verification
The hardest situation to reach is a group in which members are acknowledged in different cycles and in every order. Requests that are already done must stay low while the others are still pending, and the following group must not start early. The bench acknowledges each pending channel at random in each cycle, so groups finish over several cycles with varying orders. It combines this with random opcodes, condition codes and flag words, so that branches are taken and not taken under every condition code. Directed cases cover each class, every condition code, and the unknown opcodes.

// File: rtl/exseq_pkg.sv
package exseq_pkg;
    localparam int OP_W   = 4;
    localparam int CC_W   = 3;
    localparam int FLAG_W = 4;
    localparam int GRP_N  = 4;
    localparam int GRP_W  = $clog2(GRP_N);

    localparam int CH_REL   = 0;
    localparam int CH_OFS   = 1;
    localparam int CH_XRD   = 2;
    localparam int CH_YRD   = 3;
    localparam int CH_ALU   = 4;
    localparam int CH_ZALU  = 5;
    localparam int CH_ZRES  = 6;
    localparam int CH_ZMEM  = 7;
    localparam int CH_MLD   = 8;
    localparam int CH_MST   = 9;
    localparam int CH_XOFS  = 10;
    localparam int CH_XPC   = 11;
    localparam int CH_YPC   = 12;
    localparam int CH_FLG   = 13;
    localparam int CH_PCREL = 14;
    localparam int NCH      = 15;

    localparam int FL_ZERO  = 0;
    localparam int FL_NEG   = 1;
    localparam int FL_CARRY = 2;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'h8;
    localparam logic [OP_W-1:0] OPC_STORE = 4'h9;
    localparam logic [OP_W-1:0] OPC_ADDI  = 4'hA;
    localparam logic [OP_W-1:0] OPC_STPC  = 4'hB;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'hC;
    localparam logic [OP_W-1:0] OPC_BRCH  = 4'hD;
    localparam logic [OP_W-1:0] ALU_ADD   = 4'h0;

    localparam logic [CC_W-1:0] CC_ALWAYS = 3'd0;
    localparam logic [CC_W-1:0] CC_ZERO   = 3'd1;
    localparam logic [CC_W-1:0] CC_NZERO  = 3'd2;
    localparam logic [CC_W-1:0] CC_NEG    = 3'd3;
    localparam logic [CC_W-1:0] CC_CARRY  = 3'd4;

    typedef logic [NCH-1:0] chmask_t;
    typedef logic [GRP_N-1:0][NCH-1:0] plan_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_ADVANCE = 2'd2
    } state_t;

    function automatic chmask_t ch(input int idx);
        chmask_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/exseq_cond.sv
module exseq_cond
    import exseq_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [CC_W-1:0]   cc,
    output logic              taken
);
    always_comb begin
        unique case (cc)
            CC_ALWAYS: taken = 1'b1;
            CC_ZERO:   taken = flags[FL_ZERO];
            CC_NZERO:  taken = !flags[FL_ZERO];
            CC_NEG:    taken = flags[FL_NEG];
            CC_CARRY:  taken = flags[FL_CARRY];
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/exseq_decode.sv
module exseq_decode
    import exseq_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            taken,
    output plan_t           plan,
    output logic [OP_W-1:0] alu_op
);
    always_comb begin
        plan   = '0;
        alu_op = ALU_ADD;
        if (!op[OP_W-1]) begin
            plan[0] = ch(CH_REL);
            plan[1] = ch(CH_XRD) | ch(CH_YRD) | ch(CH_ALU) | ch(CH_ZALU) | ch(CH_ZRES);
            alu_op  = op;
        end else begin
            unique case (op)
                OPC_LOAD: begin
                    plan[0] = ch(CH_REL);
                    plan[1] = ch(CH_ZMEM) | ch(CH_YRD) | ch(CH_MLD);
                end
                OPC_STORE: begin
                    plan[0] = ch(CH_REL);
                    plan[1] = ch(CH_XRD) | ch(CH_YRD) | ch(CH_MST);
                end
                OPC_ADDI: begin
                    plan[0] = ch(CH_OFS);
                    plan[1] = ch(CH_REL);
                    plan[2] = ch(CH_XOFS) | ch(CH_YRD) | ch(CH_ALU) | ch(CH_ZALU);
                end
                OPC_STPC: begin
                    plan[0] = ch(CH_XPC) | ch(CH_YRD) | ch(CH_ALU) | ch(CH_ZALU);
                    plan[1] = ch(CH_REL);
                end
                OPC_JUMP: begin
                    plan[0] = ch(CH_YPC) | ch(CH_YRD);
                    plan[1] = ch(CH_REL);
                end
                OPC_BRCH: begin
                    plan[0] = ch(CH_OFS);
                    plan[1] = ch(CH_FLG);
                    plan[2] = taken ? ch(CH_PCREL) : '0;
                    plan[3] = ch(CH_REL);
                end
                default: begin
                    plan[0] = ch(CH_REL);
                end
            endcase
        end
    end
endmodule

// File: rtl/exseq_track.sv
module exseq_track
    import exseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    active,
    input  chmask_t mask,
    input  chmask_t ack,
    output chmask_t req,
    output logic    complete
);
    chmask_t done;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n || !active) begin
                done[i] <= 1'b0;
            end else if (req[i] && ack[i]) begin
                done[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        req      = active ? (mask & ~done) : '0;
        complete = active && ((mask & ~(done | (ack & req))) == '0);
    end
endmodule

// File: rtl/exec_sequencer.sv
module exec_sequencer
    import exseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [OP_W-1:0]   instr_op,
    input  logic [CC_W-1:0]   instr_cc,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic [NCH-1:0]    hs_req,
    input  logic [NCH-1:0]    hs_ack,
    output logic [OP_W-1:0]   alu_op
);
    state_t            state, state_nx;
    logic [GRP_W-1:0]  grp;
    logic [OP_W-1:0]   op_q;
    logic [CC_W-1:0]   cc_q;
    logic [FLAG_W-1:0] flags_q;
    logic              taken;
    plan_t             plan;
    logic              active;
    logic              complete;
    logic              last_grp;

    exseq_cond u_cond (
        .flags (flags_q),
        .cc    (cc_q),
        .taken (taken)
    );

    exseq_decode u_decode (
        .op     (op_q),
        .taken  (taken),
        .plan   (plan),
        .alu_op (alu_op)
    );

    exseq_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .mask     (plan[grp]),
        .ack      (hs_ack),
        .req      (hs_req),
        .complete (complete)
    );

    always_comb begin
        last_grp = (grp == GRP_W'(GRP_N - 1));
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (instr_valid) state_nx = ST_ISSUE;
            ST_ISSUE:   if (complete) state_nx = last_grp ? ST_IDLE : ST_ADVANCE;
            ST_ADVANCE: state_nx = ST_ISSUE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            grp     <= '0;
            op_q    <= '0;
            cc_q    <= '0;
            flags_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && instr_valid) begin
                op_q <= instr_op;
                cc_q <= instr_cc;
                grp  <= '0;
            end
            if (state == ST_ADVANCE) begin
                grp <= grp + 1'b1;
            end
            if (state == ST_ISSUE && hs_req[CH_FLG] && hs_ack[CH_FLG]) begin
                flags_q <= alu_flags;
            end
        end
    end

    always_comb begin
        instr_ready = (state == ST_IDLE);
        active      = (state == ST_ISSUE);
    end
endmodule

// File: rtl/exec_sequencer_chk.sv
module exec_sequencer_chk
    import exseq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           instr_valid,
    input logic           instr_ready,
    input logic [NCH-1:0] hs_req,
    input logic [NCH-1:0] hs_ack
);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_req & ~hs_ack) != '0) |=>
        ((hs_req & $past(hs_req & ~hs_ack)) == $past(hs_req & ~hs_ack)));

    assert_req_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_req & hs_ack) != '0) |=> ((hs_req & $past(hs_req & hs_ack)) == '0));

    assert_no_late_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req != '0) |=> ((hs_req & ~$past(hs_req)) == '0));

    assert_release_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req[CH_REL] |-> ($countones(hs_req) == 1));

    assert_busy_after_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready) |=> !instr_ready);

    assert_busy_while_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req != '0) |-> !instr_ready);
endmodule

bind exec_sequencer exec_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .hs_req      (hs_req),
    .hs_ack      (hs_ack)
);

// File: tb/exec_sequencer_bench.sv
module exec_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic         instr_ready;
    logic [3:0]   instr_op = '0;
    logic [2:0]   instr_cc = '0;
    logic [3:0]   alu_flags = '0;
    logic [N-1:0] hs_req;
    logic [N-1:0] hs_ack = '0;
    logic [3:0]   alu_op;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exec_sequencer u_exec_sequencer (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_cc(instr_cc), .alu_flags(alu_flags),
        .hs_req(hs_req), .hs_ack(hs_ack), .alu_op(alu_op)
    );

    function automatic logic [N-1:0] b(input int i);
        logic [N-1:0] m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic cond_ok(input logic [2:0] cc, input logic [3:0] f);
        case (cc)
            3'd0: return 1'b1;
            3'd1: return f[0];
            3'd2: return !f[0];
            3'd3: return f[1];
            3'd4: return f[2];
            default: return 1'b0;
        endcase
    endfunction

    // expected non-empty groups, in order; returns count
    function automatic int expect_groups(input logic [3:0] op, input logic [2:0] cc,
                                         input logic [3:0] f, output logic [3:0][N-1:0] g);
        g = '0;
        if (op < 4'd8) begin
            g[0] = b(0); g[1] = b(2) | b(3) | b(4) | b(5) | b(6); return 2;
        end
        case (op)
            4'd8:  begin g[0] = b(0); g[1] = b(7) | b(3) | b(8); return 2; end
            4'd9:  begin g[0] = b(0); g[1] = b(2) | b(3) | b(9); return 2; end
            4'd10: begin g[0] = b(1); g[1] = b(0); g[2] = b(10) | b(3) | b(4) | b(5); return 3; end
            4'd11: begin g[0] = b(11) | b(3) | b(4) | b(5); g[1] = b(0); return 2; end
            4'd12: begin g[0] = b(12) | b(3); g[1] = b(0); return 2; end
            4'd13: begin
                g[0] = b(1); g[1] = b(13);
                if (cond_ok(cc, f)) begin g[2] = b(14); g[3] = b(0); return 4; end
                g[2] = b(0); return 3;
            end
            default: begin g[0] = b(0); return 1; end
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op < 4'd8) return "R3";
        case (op)
            4'd8: return "R4";
            4'd9: return "R5";
            4'd10: return "R6";
            4'd11: return "R7";
            4'd12: return "R8";
            4'd13: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_instr(input logic [3:0] op, input logic [2:0] cc, input logic [3:0] f);
        logic [3:0][N-1:0] got, exp_g;
        logic [N-1:0] prev;
        logic [3:0]   seen_op;
        int ng, ne;
        logic fin;
        got = '0; prev = '0; seen_op = 4'hx; ng = 0; fin = 1'b0;
        while (!instr_ready) @(negedge clk);
        instr_op = op; instr_cc = cc; alu_flags = f; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check(instr_ready == 1'b0, "R12", {31'd0, instr_ready}, 32'd0);
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (instr_ready) begin fin = 1'b1; break; end
            if (hs_req != '0 && prev == '0) begin
                if (ng < 4) got[ng] = hs_req;
                ng++;
            end
            if (hs_req[4]) seen_op = alu_op;
            prev = hs_req;
            hs_ack = hs_req & N'($urandom);
            @(negedge clk);
        end
        hs_ack = '0;
        ne = expect_groups(op, cc, f, exp_g);
        check(fin, {tag_of(op), " R12 finish"}, {31'd0, fin}, 32'd1);
        check(ng == ne && got == exp_g, {tag_of(op), " R11 groups"}, got[1:0], exp_g[1:0]);
        if (op < 4'd8)
            check(seen_op == op, "R3 alu_op", {28'd0, seen_op}, {28'd0, op});
        else if (op == 4'd10 || op == 4'd11)
            check(seen_op == 4'd0, {tag_of(op), " alu_op"}, {28'd0, seen_op}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(instr_ready == 1'b1 && hs_req == '0, "R1 reset", {16'd0, instr_ready, hs_req}, 32'h8000);
        rst_n = 1'b1;
        @(negedge clk);
        check(instr_ready == 1'b1 && hs_req == '0, "R1 idle", {16'd0, instr_ready, hs_req}, 32'h8000);
        // directed: each class
        run_instr(4'd5, 3'd0, 4'd0);
        run_instr(4'd0, 3'd0, 4'd0);
        run_instr(4'd8, 3'd0, 4'd0);
        run_instr(4'd9, 3'd0, 4'd0);
        run_instr(4'd10, 3'd0, 4'd0);
        run_instr(4'd11, 3'd0, 4'd0);
        run_instr(4'd12, 3'd0, 4'd0);
        run_instr(4'd14, 3'd0, 4'd0);
        run_instr(4'd15, 3'd0, 4'd0);
        // directed: branch on every condition code, both flag polarities (R9)
        for (int c = 0; c < 8; c++) begin
            run_instr(4'd13, 3'(c), 4'h0);
            run_instr(4'd13, 3'(c), 4'hF);
        end
        run_instr(4'd13, 3'd1, 4'h1);
        run_instr(4'd13, 3'd2, 4'h1);
        // random mix
        for (int k = 0; k < 400; k++)
            run_instr(4'($urandom_range(15)), 3'($urandom_range(7)), 4'($urandom_range(15)));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule